// File: doc/BRIEF.md
# TDM Switch Processor Register Port

This block is the parallel host port of a time-slot switch. A host reaches it through a synchronous chip-select, read-strobe and write-strobe interface with a 6-bit address and 8-bit data. The top address bit picks one of two targets. When it is low, the access goes to a local control register. When it is high, the access goes to one of the switch's three memories: the data memory, the low connection memory or the high connection memory. The control register chooses which memory is used and which stream's block of 32 channels the low five address lines index. The block also exposes the control register's processor-enable flag to the switch core.

The memories themselves sit outside this block and are synchronous RAMs. The port issues a read enable, a write enable, a shared address and the write data in the same cycle as the host strobe. A read's data comes back from the selected RAM, or from a snapshot of the control register, on the host data bus one clock after the strobe. A split access mode lets software read the switched input samples while it programs connections. In this mode every memory read comes from the data memory, and every memory write goes to the connection memory named by the select field.

Top module: `tsi_cpu_port`

## Requirements
- R1: During and after reset the control register is 0x00, `proc_en` is 0 and `rdata` is 0x00.
- R2: An access with `addr[5]`=0 targets the control register. Writes store bits 7, 6, 4, 3, 1 and 0. Bits 5 and 2 always read as 0. A read returns the stored value on `rdata` one clock after the strobe.
- R3: An access with `addr[5]`=1 drives `mem_addr` = {control bits 1:0 (stream), `addr[4:0]` (channel)} in the strobe cycle, together with the matching memory strobe.
- R4: Select field (control bits 4:3) = 2'b10 selects the low connection memory. Outside split mode, writes assert `cml_we` with `mem_wdata` = `wdata`, and reads assert `cml_re` and return `cml_rdata` one clock later.
- R5: Select field = 2'b11 selects the high connection memory in the same way, through `cmh_we`, `cmh_re` and `cmh_rdata`. A write there leaves the low connection memory unchanged.
- R6: Select field = 2'b01 selects the data memory. Reads assert `dm_re` and return `dm_rdata`. Writes are ignored in every mode, and no memory write enable rises.
- R7: Select field = 2'b00 selects nothing. Memory reads return 0x00 and memory writes are ignored.
- R8: Control bit 7 set (split mode): every memory read comes from the data memory whatever the select field. Writes go to the low or high connection memory according to the select field, and are ignored when the field is 2'b01 or 2'b00. At most one memory strobe is active per cycle.
- R9: `proc_en` equals control bit 6 and changes in the cycle after the write that sets or clears it.
- R10: With `cs` low, strobes have no effect and no memory strobe rises. When `rd` and `wr` are both high with `cs`, the access is a write only.
- R11: In any cycle that does not follow an accepted read, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, qualifies both strobes |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 6 | Bit 5: memory (1) or control register (0); bits 4:0: channel |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid the clock after a read strobe |
| proc_en | output | 1 | Processor-enable flag to the switch core |
| mem_addr | output | 7 | Memory address {stream, channel} |
| mem_wdata | output | 8 | Write data to the connection memories |
| cml_we | output | 1 | Low connection memory write enable |
| cmh_we | output | 1 | High connection memory write enable |
| dm_re | output | 1 | Data memory read enable |
| cml_re | output | 1 | Low connection memory read enable |
| cmh_re | output | 1 | High connection memory read enable |
| dm_rdata | input | 8 | Data memory read data, one clock after `dm_re` |
| cml_rdata | input | 8 | Low connection memory read data, one clock after `cml_re` |
| cmh_rdata | input | 8 | High connection memory read data, one clock after `cmh_re` |

## Verification
The assertions check every cycle that:
- a deselected port raises no strobe;
- at most one memory strobe is active at a time;
- split-mode memory reads always hit the data memory;
- the data memory is never written;
- the paged address matches the stream field;
- `proc_en` and the control register change only through control writes;
- `rdata` is zero outside the cycle after a read.

Only the bench's scenarios show that data written through one select setting comes back intact after the page, select or split bits change, and that ignored writes left the memories untouched. They also show that reserved bits drop out of read-back values and that reset clears a programmed register.

// File: rtl/tsi_cpu_pkg.sv
// Package: shared encodings for the switch processor port.
// Assumes an 8-bit control register whose field positions are fixed.
package tsi_cpu_pkg;

    localparam int CR_SPLIT = 7;
    localparam int CR_PE    = 6;
    localparam int CR_SEL_H = 4;
    localparam int CR_SEL_L = 3;

    typedef enum logic [1:0] {
        MSEL_OFF = 2'b00,
        MSEL_DM  = 2'b01,
        MSEL_CML = 2'b10,
        MSEL_CMH = 2'b11
    } msel_e;

    typedef enum logic [2:0] {
        SRC_ZERO = 3'd0,
        SRC_CTRL = 3'd1,
        SRC_DM   = 3'd2,
        SRC_CML  = 3'd3,
        SRC_CMH  = 3'd4
    } rsrc_e;

endpackage

// File: rtl/tsi_cpu_ctrl_reg.sv
// Control register: holds split, processor-enable, memory-select and stream
// fields. Reserved bits are masked on write so they always read as zero.
// Assumes STR_W is 1..3 (stream field in the low bits).
module tsi_cpu_ctrl_reg
    import tsi_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              split,
    output logic              pe,
    output msel_e             msel,
    output logic [STR_W-1:0]  stream
);

    localparam logic [DATA_W-1:0] STR_MASK = DATA_W'((1 << STR_W) - 1);
    localparam logic [DATA_W-1:0] WMASK    = DATA_W'(8'hD8) | STR_MASK;

    // Register update: masked load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we)
            ctrl_q <= wdata & WMASK;
    end

    // Field extraction for the decoder and the core.
    always_comb begin
        split  = ctrl_q[CR_SPLIT];
        pe     = ctrl_q[CR_PE];
        msel   = msel_e'(ctrl_q[CR_SEL_H:CR_SEL_L]);
        stream = ctrl_q[STR_W-1:0];
    end

endmodule

// File: rtl/tsi_cpu_decode.sv
// Access decoder: turns a host strobe into a control-register write, a
// memory strobe or a read source. Write wins when rd and wr coincide.
// Writes never reach the data memory; split mode only reroutes reads.
module tsi_cpu_decode
    import tsi_cpu_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [CH_W:0] addr,
    input  logic          split,
    input  msel_e         msel,
    output logic          ctrl_we,
    output logic          cml_we,
    output logic          cmh_we,
    output logic          dm_re,
    output logic          cml_re,
    output logic          cmh_re,
    output rsrc_e         rsrc
);

    logic wr_acc;
    logic rd_acc;
    logic is_mem;

    // Qualify the strobes and split the address space.
    always_comb begin
        wr_acc = cs & wr;
        rd_acc = cs & rd & ~wr;
        is_mem = addr[CH_W];
    end

    // Write routing: control register or one connection memory.
    always_comb begin
        ctrl_we = wr_acc & ~is_mem;
        cml_we  = wr_acc & is_mem & (msel == MSEL_CML);
        cmh_we  = wr_acc & is_mem & (msel == MSEL_CMH);
    end

    // Read source selection, split mode forcing the data memory.
    always_comb begin
        rsrc = SRC_ZERO;
        if (rd_acc) begin
            if (!is_mem)
                rsrc = SRC_CTRL;
            else if (split)
                rsrc = SRC_DM;
            else begin
                case (msel)
                    MSEL_DM:  rsrc = SRC_DM;
                    MSEL_CML: rsrc = SRC_CML;
                    MSEL_CMH: rsrc = SRC_CMH;
                    default:  rsrc = SRC_ZERO;
                endcase
            end
        end
    end

    // Memory read enables follow the chosen source.
    always_comb begin
        dm_re  = (rsrc == SRC_DM);
        cml_re = (rsrc == SRC_CML);
        cmh_re = (rsrc == SRC_CMH);
    end

endmodule

// File: rtl/tsi_cpu_rdmux.sv
// Read data path: remembers the source of the previous cycle's read and
// selects matching data. Assumes RAM data arrives one clock after its enable.
module tsi_cpu_rdmux
    import tsi_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsrc_e             rsrc,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] dm_rdata,
    input  logic [DATA_W-1:0] cml_rdata,
    input  logic [DATA_W-1:0] cmh_rdata,
    output logic [DATA_W-1:0] rdata
);

    rsrc_e             src_q;
    logic [DATA_W-1:0] ctrl_snap;

    // Capture the read source and a control-register snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= SRC_ZERO;
            ctrl_snap <= '0;
        end else begin
            src_q <= rsrc;
            if (rsrc == SRC_CTRL)
                ctrl_snap <= ctrl_q;
        end
    end

    // Output multiplexer, zero when no read was accepted.
    always_comb begin
        case (src_q)
            SRC_CTRL: rdata = ctrl_snap;
            SRC_DM:   rdata = dm_rdata;
            SRC_CML:  rdata = cml_rdata;
            SRC_CMH:  rdata = cmh_rdata;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tsi_cpu_port.sv
// Top of the switch processor port: control register, access decoder and
// read multiplexer. Memories are external synchronous RAMs addressed by
// {stream, channel}; strobes are single-cycle and synchronous to clk.
module tsi_cpu_port
    import tsi_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CH_W   = 5,
    parameter int STR_W  = 2,
    localparam int MEM_AW = STR_W + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [CH_W:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              proc_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cml_we,
    output logic              cmh_we,
    output logic              dm_re,
    output logic              cml_re,
    output logic              cmh_re,
    input  logic [DATA_W-1:0] dm_rdata,
    input  logic [DATA_W-1:0] cml_rdata,
    input  logic [DATA_W-1:0] cmh_rdata
);

    logic [DATA_W-1:0] ctrl_q;
    logic              split;
    logic              pe;
    msel_e             msel;
    logic [STR_W-1:0]  stream;
    logic              ctrl_we;
    rsrc_e             rsrc;

    tsi_cpu_ctrl_reg #(.DATA_W(DATA_W), .STR_W(STR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .wdata  (wdata),
        .ctrl_q (ctrl_q),
        .split  (split),
        .pe     (pe),
        .msel   (msel),
        .stream (stream)
    );

    tsi_cpu_decode #(.CH_W(CH_W)) u_dec (
        .cs      (cs),
        .rd      (rd),
        .wr      (wr),
        .addr    (addr),
        .split   (split),
        .msel    (msel),
        .ctrl_we (ctrl_we),
        .cml_we  (cml_we),
        .cmh_we  (cmh_we),
        .dm_re   (dm_re),
        .cml_re  (cml_re),
        .cmh_re  (cmh_re),
        .rsrc    (rsrc)
    );

    tsi_cpu_rdmux #(.DATA_W(DATA_W)) u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsrc      (rsrc),
        .ctrl_q    (ctrl_q),
        .dm_rdata  (dm_rdata),
        .cml_rdata (cml_rdata),
        .cmh_rdata (cmh_rdata),
        .rdata     (rdata)
    );

    // Paged memory address, shared write data and core flag.
    always_comb begin
        mem_addr  = {stream, addr[CH_W-1:0]};
        mem_wdata = wdata;
        proc_en   = pe;
    end

endmodule

// File: rtl/tsi_cpu_port_chk.sv
// Checker for tsi_cpu_port: cycle-level properties of strobes, paging,
// control-register side effects and read-data idling. Bound to the top.
module tsi_cpu_port_chk #(
    parameter int DATA_W = 8,
    parameter int CH_W   = 5,
    parameter int STR_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs,
    input logic                    rd,
    input logic                    wr,
    input logic [CH_W:0]           addr,
    input logic [DATA_W-1:0]       wdata,
    input logic [DATA_W-1:0]       rdata,
    input logic                    proc_en,
    input logic [STR_W+CH_W-1:0]   mem_addr,
    input logic                    cml_we,
    input logic                    cmh_we,
    input logic                    dm_re,
    input logic                    cml_re,
    input logic                    cmh_re,
    input logic [DATA_W-1:0]       ctrl_q
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && !addr[CH_W]) |=> (rdata[5] == 1'b0 && (STR_W > 2 || rdata[2] == 1'b0)));

    p_addr_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && addr[CH_W] && (rd || wr)) |-> mem_addr == {ctrl_q[STR_W-1:0], addr[CH_W-1:0]});

    p_dm_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr[CH_W] && ctrl_q[4:3] == 2'b01) |-> !(cml_we || cmh_we));

    p_split_reads_dm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && addr[CH_W] && ctrl_q[7]) |-> (dm_re && !cml_re && !cmh_re));

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cml_we, cmh_we, dm_re, cml_re, cmh_re}));

    p_pe_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !addr[CH_W]) |=> proc_en == $past(wdata[6]));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !(cml_we || cmh_we || dm_re || cml_re || cmh_re));

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr && !addr[CH_W]) |=> $stable(ctrl_q));

    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd && !wr) |=> rdata == '0);

endmodule

bind tsi_cpu_port tsi_cpu_port_chk #(.DATA_W(DATA_W), .CH_W(CH_W), .STR_W(STR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .proc_en  (proc_en),
    .mem_addr (mem_addr),
    .cml_we   (cml_we),
    .cmh_we   (cmh_we),
    .dm_re    (dm_re),
    .cml_re   (cml_re),
    .cmh_re   (cmh_re),
    .ctrl_q   (ctrl_q)
);

// File: tb/tsi_cpu_port_bench.sv
// Bench for tsi_cpu_port: models the three RAMs, walks a vector table of
// host accesses, then runs directed reset and corner-case tests.
module tsi_cpu_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       proc_en;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       cml_we, cmh_we, dm_re, cml_re, cmh_re;
    logic [7:0] dm_q, cml_q, cmh_q;
    logic [7:0] cml_m [128];
    logic [7:0] cmh_m [128];

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tsi_cpu_port u_tsi_cpu_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .proc_en(proc_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cml_we(cml_we), .cmh_we(cmh_we), .dm_re(dm_re),
        .cml_re(cml_re), .cmh_re(cmh_re), .dm_rdata(dm_q), .cml_rdata(cml_q),
        .cmh_rdata(cmh_q)
    );

    function automatic logic [7:0] dm_val(input logic [6:0] a);
        return 8'(a * 3 + 7);
    endfunction

    // Synchronous RAM models; connection memories clear on reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) begin
                cml_m[i] <= '0;
                cmh_m[i] <= '0;
            end
            dm_q <= '0; cml_q <= '0; cmh_q <= '0;
        end else begin
            if (cml_we) cml_m[mem_addr] <= mem_wdata;
            if (cmh_we) cmh_m[mem_addr] <= mem_wdata;
            if (dm_re)  dm_q  <= dm_val(mem_addr);
            if (cml_re) cml_q <= cml_m[mem_addr];
            if (cmh_re) cmh_q <= cmh_m[mem_addr];
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One host access; returns rdata sampled the clock after the strobe.
    task automatic access(input logic w, input logic [5:0] a, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        cs = 1'b1; rd = ~w; wr = w; addr = a; wdata = d;
        @(negedge clk);
        q = rdata;
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    typedef struct packed {
        logic       w;
        logic [5:0] a;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'h00, 8'h16, 8'h00},  // R2 write with reserved bit 2 set
        '{1'b0, 6'h00, 8'h00, 8'h12},  // R2 read back, reserved dropped
        '{1'b1, 6'h25, 8'hA5, 8'h00},  // R4 CML[69]
        '{1'b0, 6'h25, 8'h00, 8'hA5},  // R4 R3 read CML stream 2
        '{1'b1, 6'h00, 8'h1A, 8'h00},  // R5 select CMH
        '{1'b1, 6'h25, 8'h3C, 8'h00},  // R5 CMH[69]
        '{1'b0, 6'h25, 8'h00, 8'h3C},  // R5
        '{1'b1, 6'h00, 8'h12, 8'h00},  // R5 back to CML
        '{1'b0, 6'h25, 8'h00, 8'hA5},  // R5 CML untouched
        '{1'b1, 6'h00, 8'h09, 8'h00},  // R6 select DM stream 1
        '{1'b0, 6'h27, 8'h00, 8'h7C},  // R6 DM[39]
        '{1'b1, 6'h27, 8'hEE, 8'h00},  // R6 write ignored
        '{1'b0, 6'h27, 8'h00, 8'h7C},  // R6
        '{1'b1, 6'h00, 8'h93, 8'h00},  // R8 split, CML, stream 3
        '{1'b1, 6'h21, 8'h55, 8'h00},  // R8 write CML[97]
        '{1'b0, 6'h21, 8'h00, 8'h2A},  // R8 read from DM[97]
        '{1'b1, 6'h00, 8'h13, 8'h00},  // R8 leave split
        '{1'b0, 6'h21, 8'h00, 8'h55},  // R8 CML[97] holds written value
        '{1'b1, 6'h00, 8'h00, 8'h00},  // R7 select none
        '{1'b0, 6'h21, 8'h00, 8'h00},  // R7 read gives zero
        '{1'b1, 6'h21, 8'h77, 8'h00},  // R7 write ignored
        '{1'b1, 6'h00, 8'h10, 8'h00},  // R7 CML stream 0
        '{1'b0, 6'h21, 8'h00, 8'h00},  // R7 CML[1] untouched
        '{1'b1, 6'h00, 8'h8B, 8'h00},  // R8 split with DM select
        '{1'b1, 6'h21, 8'h99, 8'h00},  // R8 write ignored
        '{1'b1, 6'h00, 8'h13, 8'h00},  // R8
        '{1'b0, 6'h21, 8'h00, 8'h55},  // R8 CML[97] unchanged
        '{1'b1, 6'h00, 8'h4F, 8'h00},  // R2 R9 set PE
        '{1'b0, 6'h00, 8'h00, 8'h4B}   // R2
    };

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, 8'h00);
        check("R1 proc_en in reset", {7'd0, proc_en}, 8'h00);
        rst_n = 1'b1;
        access(1'b0, 6'h00, 8'h00, q);
        check("R1 control after reset", q, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].w, VEC[i].a, VEC[i].d, q);
            if (!VEC[i].w) check($sformatf("vector %0d", i), q, VEC[i].e);
        end

        check("R9 proc_en set", {7'd0, proc_en}, 8'h01);
        access(1'b1, 6'h00, 8'h00, q);
        check("R9 proc_en cleared", {7'd0, proc_en}, 8'h00);

        // R10: strobes without chip select
        @(negedge clk);
        cs = 1'b0; wr = 1'b1; rd = 1'b0; addr = 6'h00; wdata = 8'hFF;
        #1 check("R10 no strobe without cs", {3'd0, cml_we, cmh_we, dm_re, cml_re, cmh_re}, 8'h00);
        @(negedge clk);
        wr = 1'b0;
        access(1'b0, 6'h00, 8'h00, q);
        check("R10 control unchanged", q, 8'h00);

        // R10 R11: rd and wr together act as a write
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; wr = 1'b1; addr = 6'h00; wdata = 8'h10;
        @(negedge clk);
        check("R11 no read data after rd+wr", rdata, 8'h00);
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
        access(1'b0, 6'h00, 8'h00, q);
        check("R10 rd+wr wrote control", q, 8'h10);

        // R3: paged address and DM strobe in the strobe cycle
        access(1'b1, 6'h00, 8'h0A, q);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = 6'h3F;
        #1 check("R3 mem_addr", {1'b0, mem_addr}, 8'h5F);
        check("R6 dm_re on read", {7'd0, dm_re}, 8'h01);
        @(negedge clk);
        check("R6 DM data", rdata, 8'h24);
        cs = 1'b0; rd = 1'b0;
        @(negedge clk);
        check("R11 idle rdata", rdata, 8'h00);

        // R1: reset clears a programmed register
        access(1'b1, 6'h00, 8'h40, q);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 proc_en after reset", {7'd0, proc_en}, 8'h00);
        rst_n = 1'b1;
        access(1'b0, 6'h00, 8'h00, q);
        check("R1 control after second reset", q, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule